// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates 32-bit virtual addresses to physical addresses by walking a two-level table tree held in ordinary memory. A requester presents a virtual address, a write flag and a user-mode flag. The walker fetches the first-level (directory) entry at the root table named by a base register. Unless that entry maps a 4 MiB large page, it then fetches the second-level entry. It returns either the physical address or a fault with a cause code and the level that failed.

On a successful walk the walker maintains the usage flags in memory. It writes back each entry it consulted whose accessed flag was clear. On a write it also sets the dirty flag in the entry that supplied the frame. Memory is reached through one word-wide port that carries one request at a time, and the walker serves one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: The first memory access of a walk reads address `{ptbr[31:12], va[31:22], 2'b00}`. The second-level access reads `{dir_entry[31:12], va[21:12], 2'b00}`.
- R3: A walk through a present second-level entry returns `resp_pa = {pte[31:12], va[11:0]}` with `resp_fault` = 0.
- R4: A present directory entry with bit 7 set ends the walk at level 1 and returns `resp_pa = {dir[31:22], va[21:0]}`.
- R5: An entry with bit 0 (present) clear faults with cause 1, whatever its other bits hold. `resp_level` is 1 for the directory and 2 for the second level, and `resp_va` returns the request address.
- R6: A write to an entry whose bit 1 (writable) is clear faults with cause 2, at either level. This cause ranks above the privilege fault.
- R7: A user access (`req_user` = 1) to an entry whose bit 2 (user) is clear faults with cause 3, at either level.
- R8: After a successful walk, every entry used whose bit 5 (accessed) was clear has been rewritten in memory with bit 5 set. All its other bits are kept.
- R9: After a successful write walk, the final entry (the second-level entry, or the directory entry for a large page) has bit 6 (dirty) set.
- R10: A walk that faults writes nothing to memory.
- R11: `ready` falls on the cycle after a request is accepted and stays low until the response. `resp_valid` is a single-cycle pulse.
- R12: `mem_req` stays high with a stable address until `mem_ack`, and `mem_we` is never high without `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when `ready` is 1 |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access |
| req_user | input | 1 | 1 for a user-mode access |
| ptbr | input | 32 | Root table base; bits 31:12 are used |
| ready | output | 1 | Walker idle and able to accept a request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | 1 when the walk faulted |
| resp_pa | output | 32 | Physical address on success |
| resp_cause | output | 2 | 0 none, 1 not present, 2 write-protect, 3 privilege |
| resp_level | output | 2 | Faulting level, 1 or 2; 0 on success |
| resp_va | output | 32 | Virtual address of the finished walk |

## Verification
The bench builds the walker with its default 32-bit address and 12-bit offset, so each table holds 1024 entries. A compact memory model places one root table and two second-level tables in a 16 KiB window. This arrangement puts every branch of the walk within reach: a large page, faults at both levels, the precedence among causes, and walks that need zero, one or two writebacks. Reading the modelled memory after the walks shows which entries received accessed and dirty updates and which stayed untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag positions (decoded by the walker and by software tables)
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_ACC     = 5;
  localparam int unsigned BIT_DIRTY   = 6;
  localparam int unsigned BIT_LARGE   = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_WPROT  = 2'd2,
    CAUSE_PRIV   = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RDIR, S_RPTE, S_WDIR, S_WPTE
  } walk_st_e;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] entry,
  input  logic          is_write,
  input  logic          is_user,
  output cause_e        cause
);
  // presence first; remaining flags are meaningless on an absent entry
  always_comb begin
    if (!entry[BIT_PRESENT])                cause = CAUSE_ABSENT;
    else if (is_write && !entry[BIT_WRITE]) cause = CAUSE_WPROT;
    else if (is_user && !entry[BIT_USER])   cause = CAUSE_PRIV;
    else                                    cause = CAUSE_NONE;
  end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0] root,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] dir_ent,
  input  logic [AW-1:0] fin_ent,
  output logic [AW-1:0] dir_addr,
  output logic [AW-1:0] pte_addr,
  output logic [AW-1:0] pa_small,
  output logic [AW-1:0] pa_large
);
  localparam int IDX_W = OFF_W - 2;      // 4-byte entries fill one page
  localparam int SPAN  = IDX_W + OFF_W;  // bits covered by one directory entry

  assign dir_addr = {root[AW-1:OFF_W], va[AW-1:SPAN], 2'b00};
  assign pte_addr = {dir_ent[AW-1:OFF_W], va[SPAN-1:OFF_W], 2'b00};
  assign pa_small = {fin_ent[AW-1:OFF_W], va[OFF_W-1:0]};
  assign pa_large = {dir_ent[AW-1:SPAN], va[SPAN-1:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_va,
  input  logic          req_write,
  input  logic          req_user,
  input  logic [AW-1:0] ptbr,
  output logic          ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          resp_valid,
  output logic          resp_fault,
  output logic [AW-1:0] resp_pa,
  output logic [1:0]    resp_cause,
  output logic [1:0]    resp_level,
  output logic [AW-1:0] resp_va
);
  walk_st_e      state;
  logic [AW-1:0] va_q, dir_q, pte_q;
  logic          wr_q, usr_q, large_q;

  logic [AW-1:0] dir_src, fin_src;
  logic [AW-1:0] dir_addr, pte_addr, pa_small, pa_large;
  cause_e        chk;

  // freshly read data is used in the cycle it arrives
  assign dir_src = (state == S_RDIR) ? mem_rdata : dir_q;
  assign fin_src = (state == S_RPTE) ? mem_rdata : pte_q;

  ptw_addr #(.AW(AW), .OFF_W(OFF_W)) u_addr (
    .root(ptbr), .va(va_q), .dir_ent(dir_src), .fin_ent(fin_src),
    .dir_addr(dir_addr), .pte_addr(pte_addr),
    .pa_small(pa_small), .pa_large(pa_large)
  );

  ptw_perm #(.DW(AW)) u_perm (
    .entry(mem_rdata), .is_write(wr_q), .is_user(usr_q), .cause(chk)
  );

  function automatic logic need_wb(input logic [AW-1:0] e, input logic last);
    return !e[BIT_ACC] || (last && wr_q && !e[BIT_DIRTY]);
  endfunction

  function automatic logic [AW-1:0] mark(input logic [AW-1:0] e, input logic last);
    logic [AW-1:0] r;
    r = e;
    r[BIT_ACC] = 1'b1;
    if (last && wr_q) r[BIT_DIRTY] = 1'b1;
    return r;
  endfunction

  assign ready   = (state == S_IDLE);
  assign mem_req = (state != S_IDLE);
  assign mem_we  = (state == S_WDIR) || (state == S_WPTE);

  always_comb begin
    mem_addr  = dir_addr;
    mem_wdata = '0;
    case (state)
      S_RPTE:  mem_addr = pte_addr;
      S_WDIR:  mem_wdata = mark(dir_q, large_q);
      S_WPTE: begin
        mem_addr  = pte_addr;
        mem_wdata = mark(pte_q, 1'b1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      va_q       <= '0;
      dir_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      large_q    <= 1'b0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_pa    <= '0;
      resp_cause <= 2'd0;
      resp_level <= 2'd0;
      resp_va    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          wr_q    <= req_write;
          usr_q   <= req_user;
          large_q <= 1'b0;
          state   <= S_RDIR;
        end
        S_RDIR: if (mem_ack) begin
          dir_q <= mem_rdata;
          if (chk != CAUSE_NONE) begin
            state <= S_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b1;
            resp_cause <= chk; resp_level <= 2'd1; resp_va <= va_q; resp_pa <= '0;
          end else if (mem_rdata[BIT_LARGE]) begin
            large_q <= 1'b1;
            if (need_wb(mem_rdata, 1'b1)) state <= S_WDIR;
            else begin
              state <= S_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
              resp_cause <= 2'd0; resp_level <= 2'd0; resp_va <= va_q; resp_pa <= pa_large;
            end
          end else begin
            state <= S_RPTE;
          end
        end
        S_RPTE: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (chk != CAUSE_NONE) begin
            state <= S_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b1;
            resp_cause <= chk; resp_level <= 2'd2; resp_va <= va_q; resp_pa <= '0;
          end else if (need_wb(dir_q, 1'b0)) begin
            state <= S_WDIR;
          end else if (need_wb(mem_rdata, 1'b1)) begin
            state <= S_WPTE;
          end else begin
            state <= S_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
            resp_cause <= 2'd0; resp_level <= 2'd0; resp_va <= va_q; resp_pa <= pa_small;
          end
        end
        S_WDIR: if (mem_ack) begin
          if (!large_q && need_wb(pte_q, 1'b1)) begin
            state <= S_WPTE;
          end else begin
            state <= S_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
            resp_cause <= 2'd0; resp_level <= 2'd0; resp_va <= va_q;
            resp_pa <= large_q ? pa_large : pa_small;
          end
        end
        S_WPTE: if (mem_ack) begin
          state <= S_IDLE; resp_valid <= 1'b1; resp_fault <= 1'b0;
          resp_cause <= 2'd0; resp_level <= 2'd0; resp_va <= va_q; resp_pa <= pa_small;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          resp_valid,
  input logic          resp_fault,
  input logic [1:0]    resp_cause,
  input logic [1:0]    resp_level
);
  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> !ready);
  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R12
  we_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
  // R8
  wb_sets_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[5]);
  // R5
  fault_info_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_cause != 2'd0 && (resp_level == 2'd1 || resp_level == 2'd2)));
  // R11
  idle_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> !mem_req);
endmodule

bind pt_walker ptw_chk #(.AW(AW)) u_ptw_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .resp_valid(resp_valid), .resp_fault(resp_fault),
  .resp_cause(resp_cause), .resp_level(resp_level)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_va = '0;
  logic [31:0] ptbr = 32'h0000_1000;
  logic        ready, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_pa, resp_va;
  logic [1:0]  resp_cause, resp_level;

  int checks = 0, fails = 0;
  logic [31:0] mem [4096];

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .ptbr(ptbr), .ready(ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_pa(resp_pa), .resp_cause(resp_cause),
    .resp_level(resp_level), .resp_va(resp_va)
  );

  // memory model: ack one cycle after request, word index from addr[13:2]
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
      mem[1024+0] <= 32'h0000_2007;  // dir0: P W U, A clear
      mem[1024+1] <= 32'h0000_3025;  // dir1: P U A, read-only
      mem[1024+2] <= 32'h0000_2023;  // dir2: P W A, kernel
      mem[1024+3] <= 32'hFFFF_FFFE;  // dir3: absent, garbage flags
      mem[1024+4] <= 32'h48C0_0087;  // dir4: large, P W U
      mem[2048+0] <= 32'h0ABC_D007;
      mem[2048+1] <= 32'h0001_1025;
      mem[2048+2] <= 32'h0002_2023;
      mem[2048+3] <= 32'hFFFF_FFFE;
      mem[2048+4] <= 32'h0004_4001;
      mem[3072+0] <= 32'h0003_3067;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_ack && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    end
  end

  // {va, write, user, fault, cause, level, pa}
  localparam int NV = 14;
  localparam logic [70:0] VEC [NV] = '{
    {32'h0000_0123, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0ABC_D123},
    {32'h0000_1FFF, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0001_1FFF},
    {32'h0000_1000, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 32'h0},
    {32'h0000_2000, 1'b0, 1'b1, 1'b1, 2'd3, 2'd2, 32'h0},
    {32'h0000_2004, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0002_2004},
    {32'h0000_3000, 1'b0, 1'b0, 1'b1, 2'd1, 2'd2, 32'h0},
    {32'h00C0_0000, 1'b0, 1'b0, 1'b1, 2'd1, 2'd1, 32'h0},
    {32'h0040_0000, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 32'h0},
    {32'h0040_00AB, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 32'h0003_30AB},
    {32'h0080_0010, 1'b0, 1'b1, 1'b1, 2'd3, 2'd1, 32'h0},
    {32'h0080_0010, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0ABC_D010},
    {32'h012A_BCDE, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 32'h48EA_BCDE},
    {32'h0040_0000, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 32'h0},
    {32'h0000_4000, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 32'h0}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic flt, input logic [1:0] cause, input logic [31:0] va);
    if (flt) return (cause == 2'd1) ? "R5" : (cause == 2'd2) ? "R6" : "R7";
    return (va[31:22] == 10'd4) ? "R4" : "R3";
  endfunction

  task automatic walk(input logic [70:0] v);
    logic [31:0] va;
    string t;
    int n;
    va = v[70:39];
    t  = tag_of(v[36], v[35:34], va);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_va = va; req_write = v[38]; req_user = v[37]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", "ready while busy", {31'd0, ready}, 32'd0);
    check("R2", "root entry address", mem_addr, {ptbr[31:12], va[31:22], 2'b00});
    n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
    check(t, "fault flag", {31'd0, resp_fault}, {31'd0, v[36]});
    if (v[36]) begin
      check(t, "cause", {30'd0, resp_cause}, {30'd0, v[35:34]});
      check(t, "level", {30'd0, resp_level}, {30'd0, v[33:32]});
      check("R5", "fault va", resp_va, va);
    end else begin
      check(t, "physical address", resp_pa, v[31:0]);
    end
    @(negedge clk);
    check("R11", "single-cycle strobe", {31'd0, resp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ready in reset", {31'd0, ready}, 32'd1);
    check("R1", "resp_valid in reset", {31'd0, resp_valid}, 32'd0);
    check("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ready after reset", {31'd0, ready}, 32'd1);
    check("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) walk(VEC[i]);

    // R8 accessed flag written back into dir0 and pte0 by the first walk
    check("R8", "dir0 accessed", mem[1024+0], 32'h0000_2027);
    check("R8", "pte0 accessed", mem[2048+0], 32'h0ABC_D027);
    // R9 dirty flag in final entry, and in large directory entry
    check("R9", "pte2 dirty", mem[2048+2], 32'h0002_2063);
    check("R9", "large dir dirty", mem[1024+4], 32'h48C0_00E7);
    // R10 faulting walks leave entries unchanged
    check("R10", "pte4 untouched", mem[2048+4], 32'h0004_4001);
    check("R10", "pte1 untouched", mem[2048+1], 32'h0001_1025);
    check("R10", "dir1 untouched", mem[1024+1], 32'h0000_3025);
    check("R10", "absent dir untouched", mem[1024+3], 32'hFFFF_FFFE);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule